// File: doc/BRIEF.md
# Serial Low-Side Driver Fault Checker (SPI Host)

This block is the host side of a serial link to an eight-channel low-side output driver. Software or a parent sequencer gives it a control byte and a one-cycle start pulse. The block then runs a complete diagnosis without further help.

The diagnosis has four steps. The block shifts the byte out over an SPI-style link: chip enable (active low), serial clock and serial data out. It keeps chip enable high for a settle interval so that the outputs can reach their final level. It then shifts the same byte out a second time. While it does so, it collects the diagnostic byte that the driver returns on its serial data line.

Each returned bit shows the voltage level of one output pin: 1 means high, 0 means low. Control bits use inverted sense: 0 turns a channel on and 1 turns it off. The block compares each sent bit with its returned bit.
- A channel that was commanded on but still reads high is reported as shorted or overloaded.
- A channel that was commanded off but reads low is reported as open.

Both flag vectors are presented together with a one-cycle done pulse. They are held until the next diagnosis completes. Only a single driver on the link is supported; each transfer is exactly one byte.

Top module: `drvchk_host`

## Requirements
- R1: Each transfer sends the control byte with bit 7 (channel 7) first and bit 0 last. Bit 0 of `ctrl_i` belongs to channel 0. The byte goes out unmodified (0 = channel on, 1 = channel off), so that after the sequence the driver holds exactly `ctrl_i`.
- R2: `sclk_o` is low in the cycle before and the cycle after every change of `ce_n_o`. `sclk_o` is never high while `ce_n_o` is high.
- R3: `si_o` changes only while `sclk_o` is rising or while chip enable is being asserted, so it is stable at every falling `sclk_o` edge. `so_i` is sampled in the last cycle of each high phase, after the driver has updated it.
- R4: Each high phase of `sclk_o` lasts exactly HALF_CYC clock cycles, and each low phase between bits lasts exactly HALF_CYC cycles. Chip enable is low for at least LEAD_CYC cycles before the first rising `sclk_o` edge. Chip enable stays low for at least LEAD_CYC cycles after the last falling `sclk_o` edge.
- R5: A diagnosis consists of exactly two transfers of the same byte. `ce_n_o` stays high for at least SETTLE_CYC cycles between them.
- R6: `short_o[c]` is 1 when channel c was sent as 0 (on) and the second transfer returned 1 for it.
- R7: `open_o[c]` is 1 when channel c was sent as 1 (off) and the second transfer returned 0 for it.
- R8: `done_o` is high for exactly one cycle per diagnosis. The flags take their new values in that same cycle and stay unchanged until the next `done_o`. `busy_o` is high from the cycle after an accepted start until the `done_o` cycle, and it is low in the `done_o` cycle.
- R9: A start pulse that arrives while `busy_o` is high has no effect: the running diagnosis keeps its byte and no extra transfer follows. A start pulse in the `done_o` cycle is accepted.
- R10: After reset the outputs are: `ce_n_o` = 1, `sclk_o` = 0, `si_o` = 1, `busy_o` = 0, `done_o` = 0, and both flag vectors are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to run a diagnosis |
| ctrl_i | input | NCH | Control byte, captured when start is accepted (0 = on, 1 = off) |
| busy_o | output | 1 | A diagnosis is in progress |
| done_o | output | 1 | One-cycle pulse; the flags are valid from this cycle on |
| short_o | output | NCH | Per-channel short or overload flag |
| open_o | output | NCH | Per-channel open-load flag |
| ce_n_o | output | 1 | Chip enable to the driver, active low |
| sclk_o | output | 1 | Serial clock to the driver |
| si_o | output | 1 | Serial data to the driver |
| so_i | input | 1 | Diagnostic serial data from the driver |

## Verification
Two functions can meet in the same cycle: the completion of one diagnosis (the done pulse and the flag update) and the acceptance of a new start pulse. The bench provokes this by waiting for `done_o` and raising `start_i` in that very cycle with a different byte and different injected faults. It then checks two things. First, the flags seen at that done pulse belong to the old byte. Second, `busy_o` is high in the next cycle, and the new diagnosis later reports flags computed from the new byte. A further case raises start in the middle of a running sequence. The bench judges this case by the driver model's final latch content and by the number of chip-enable falls, which must be exactly two.

// File: rtl/drvchk_pkg.sv
package drvchk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LEAD   = 3'd1,
    ST_HIGH   = 3'd2,
    ST_LOW    = 3'd3,
    ST_LAG    = 3'd4,
    ST_SETTLE = 3'd5
  } seq_state_e;

  // Inverted command sense: a 0 sent means the channel was commanded on.
  function automatic logic short_hit(input logic sent, input logic seen);
    return (~sent) & seen;
  endfunction

  function automatic logic open_hit(input logic sent, input logic seen);
    return sent & (~seen);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Chip enable is asserted in every state that belongs to a transfer.
  function automatic logic in_transfer(input seq_state_e s);
    return (s == ST_LEAD) || (s == ST_HIGH) || (s == ST_LOW) || (s == ST_LAG);
  endfunction

endpackage

// File: rtl/drvchk_pace.sv
module drvchk_pace #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/drvchk_shift.sv
module drvchk_shift #(
  parameter int NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_n_i,
  input  logic           load_i,
  input  logic [NCH-1:0] data_i,
  input  logic           adv_i,
  input  logic           cap_i,
  input  logic           so_i,
  output logic           si_o,
  output logic [NCH-1:0] rx_o
);

  logic [NCH-1:0] tx_q;
  logic [NCH-1:0] rx_q;

  // The transmit register idles at all ones so that the line rests at "off".
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      tx_q <= '1;
    end else if (load_i) begin
      tx_q <= data_i;
    end else if (adv_i) begin
      tx_q <= {tx_q[NCH-2:0], 1'b1};
    end
  end

  // The first bit received is the highest channel, so it ends up at the top.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rx_q <= '0;
    end else if (cap_i) begin
      rx_q <= {rx_q[NCH-2:0], so_i};
    end
  end

  assign si_o = tx_q[NCH-1];
  assign rx_o = rx_q;

endmodule

// File: rtl/drvchk_decode.sv
module drvchk_decode
  import drvchk_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0] sent_i,
  input  logic [NCH-1:0] seen_i,
  output logic [NCH-1:0] short_o,
  output logic [NCH-1:0] open_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign short_o[c] = short_hit(sent_i[c], seen_i[c]);
    assign open_o[c]  = open_hit(sent_i[c], seen_i[c]);
  end

endmodule

// File: rtl/drvchk_host.sv
module drvchk_host
  import drvchk_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int HALF_CYC   = 32,
  parameter int LEAD_CYC   = 32,
  parameter int SETTLE_CYC = 20000
) (
  input  logic           clk_i,
  input  logic           rst_n_i,
  input  logic           start_i,
  input  logic [NCH-1:0] ctrl_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [NCH-1:0] short_o,
  output logic [NCH-1:0] open_o,
  output logic           ce_n_o,
  output logic           sclk_o,
  output logic           si_o,
  input  logic           so_i
);

  localparam int LONGEST = max3(HALF_CYC, LEAD_CYC, SETTLE_CYC);
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam int BIT_W   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NCH - 1);

  seq_state_e       state_q, state_d;
  logic             pass_q;
  logic [BIT_W-1:0] bit_q;
  logic [NCH-1:0]   byte_q;
  logic [NCH-1:0]   short_q, open_q;
  logic             done_q, ce_n_q, sclk_q;

  // Named internal events.
  logic             timer_zero;
  logic             phase_end;
  logic             accept_start;
  logic             sample_so;
  logic             next_bit;
  logic             relaunch;
  logic             finish;
  logic             enter_state;
  logic [CNT_W-1:0] phase_len;
  logic [NCH-1:0]   rx_byte;
  logic [NCH-1:0]   short_new, open_new;

  function automatic logic [CNT_W-1:0] span_of(input seq_state_e s);
    case (s)
      ST_LEAD, ST_LAG:  span_of = CNT_W'(LEAD_CYC - 1);
      ST_HIGH, ST_LOW:  span_of = CNT_W'(HALF_CYC - 1);
      ST_SETTLE:        span_of = CNT_W'(SETTLE_CYC - 1);
      default:          span_of = '0;
    endcase
  endfunction

  assign phase_end    = (state_q != ST_IDLE) && timer_zero;
  assign accept_start = (state_q == ST_IDLE) && start_i;
  assign sample_so    = phase_end && (state_q == ST_HIGH);
  assign next_bit     = phase_end && (state_q == ST_LOW) && (bit_q != LAST_BIT);
  assign relaunch     = phase_end && (state_q == ST_SETTLE);
  assign finish       = phase_end && (state_q == ST_LAG) && pass_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start_i)   state_d = ST_LEAD;
      ST_LEAD:   if (timer_zero) state_d = ST_HIGH;
      ST_HIGH:   if (timer_zero) state_d = ST_LOW;
      ST_LOW:    if (timer_zero) state_d = (bit_q == LAST_BIT) ? ST_LAG : ST_HIGH;
      ST_LAG:    if (timer_zero) state_d = pass_q ? ST_IDLE : ST_SETTLE;
      ST_SETTLE: if (timer_zero) state_d = ST_LEAD;
      default:                   state_d = ST_IDLE;
    endcase
  end

  assign enter_state = (state_d != state_q);
  assign phase_len   = span_of(state_d);

  drvchk_pace #(.CNT_W(CNT_W)) u_pace (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .load_i  (enter_state),
    .val_i   (phase_len),
    .zero_o  (timer_zero)
  );

  drvchk_shift #(.NCH(NCH)) u_shift (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .load_i  (accept_start || relaunch),
    .data_i  (accept_start ? ctrl_i : byte_q),
    .adv_i   (next_bit),
    .cap_i   (sample_so),
    .so_i    (so_i),
    .si_o    (si_o),
    .rx_o    (rx_byte)
  );

  drvchk_decode #(.NCH(NCH)) u_decode (
    .sent_i  (byte_q),
    .seen_i  (rx_byte),
    .short_o (short_new),
    .open_o  (open_new)
  );

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      pass_q  <= 1'b0;
      bit_q   <= '0;
      byte_q  <= '1;
    end else begin
      state_q <= state_d;
      if (accept_start) begin
        byte_q <= ctrl_i;
        pass_q <= 1'b0;
        bit_q  <= '0;
      end else if (relaunch) begin
        pass_q <= 1'b1;
        bit_q  <= '0;
      end else if (next_bit) begin
        bit_q  <= bit_q + 1'b1;
      end
    end
  end

  // The pins are registered from the next state so that they cannot glitch.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ce_n_q <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      ce_n_q <= ~in_transfer(state_d);
      sclk_q <= (state_d == ST_HIGH);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      short_q <= '0;
      open_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) begin
        short_q <= short_new;
        open_q  <= open_new;
      end
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign short_o = short_q;
  assign open_o  = open_q;
  assign ce_n_o  = ce_n_q;
  assign sclk_o  = sclk_q;

endmodule

// File: rtl/drvchk_host_chk.sv
module drvchk_host_chk #(
  parameter int NCH        = 8,
  parameter int HALF_CYC   = 32,
  parameter int LEAD_CYC   = 32,
  parameter int SETTLE_CYC = 20000
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ce_n,
  input logic           sclk,
  input logic           si,
  input logic           busy,
  input logic           done,
  input logic [NCH-1:0] short_f,
  input logic [NCH-1:0] open_f
);

  logic [31:0] hi_cnt, lo_cnt, ce_low_cnt, gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt     <= '0;
      lo_cnt     <= '0;
      ce_low_cnt <= '0;
      gap_cnt    <= '0;
    end else begin
      hi_cnt     <= sclk ? hi_cnt + 1 : '0;
      lo_cnt     <= sclk ? '0 : lo_cnt + 1;
      ce_low_cnt <= ce_n ? '0 : ce_low_cnt + 1;
      if (!busy)     gap_cnt <= '0;
      else if (ce_n) gap_cnt <= gap_cnt + 1;
      else           gap_cnt <= '0;
    end
  end

  assert_ce_fall_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_n) |-> (!sclk && !$past(sclk)));
  assert_ce_rise_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |-> (!sclk && !$past(sclk)));
  assert_sclk_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !sclk);
  assert_si_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(si));
  assert_high_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_cnt == 32'(HALF_CYC)));
  assert_low_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (lo_cnt >= 32'(HALF_CYC)));
  assert_lead_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (ce_low_cnt >= 32'(LEAD_CYC)));
  assert_lag_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |-> (lo_cnt >= 32'(LEAD_CYC)));
  assert_settle_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ce_n) && $past(busy)) |-> (gap_cnt >= 32'(SETTLE_CYC)));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(short_f) && $stable(open_f)));

endmodule

bind drvchk_host drvchk_host_chk #(
  .NCH        (NCH),
  .HALF_CYC   (HALF_CYC),
  .LEAD_CYC   (LEAD_CYC),
  .SETTLE_CYC (SETTLE_CYC)
) u_chk (
  .clk     (clk_i),
  .rst_n   (rst_n_i),
  .ce_n    (ce_n_o),
  .sclk    (sclk_o),
  .si      (si_o),
  .busy    (busy_o),
  .done    (done_o),
  .short_f (short_o),
  .open_f  (open_o)
);

// File: tb/test_drvchk_host.sv
module test_drvchk_host;

  localparam int HALF   = 3;
  localparam int LEAD   = 4;
  localparam int SETTLE = 50;
  localparam int NVEC   = 10;
  localparam int LIMIT  = 2000;

  // Each entry: {control byte, injected shorts, injected opens}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h00_00_00, 24'hFF_00_00, 24'h00_FF_00, 24'hFF_00_FF, 24'hA5_FF_FF,
    24'h0F_F0_0F, 24'hF0_0F_0F, 24'h80_7F_80, 24'h01_02_01, 24'h3C_C3_3C
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic busy, done, ce_n, sclk, si;
  logic [7:0] short_f, open_f;

  // Driver model state.
  logic [7:0] sinj = 8'h00, oinj = 8'h00;
  logic [7:0] sr_m = 8'hFF, latch_m = 8'hFF;
  logic [7:0] lvl;
  logic so_m = 1'b0;
  logic ce_d = 1'b1;

  int errs = 0, checks = 0;
  int hi_run, lo_run, gap_run, min_hi, min_lo, min_gap, falls, bad_edge;
  logic prev_sclk = 1'b0, prev_ce = 1'b1;

  always #4 clk = ~clk;

  drvchk_host #(.NCH(8), .HALF_CYC(HALF), .LEAD_CYC(LEAD), .SETTLE_CYC(SETTLE)) i_drvchk_host (
    .clk_i(clk), .rst_n_i(rst_n), .start_i(start), .ctrl_i(ctrl),
    .busy_o(busy), .done_o(done), .short_o(short_f), .open_o(open_f),
    .ce_n_o(ce_n), .sclk_o(sclk), .si_o(si), .so_i(so_m)
  );

  // Output pin level: commanded on -> low unless shorted; off -> high unless open.
  assign lvl = (latch_m & ~oinj) | (~latch_m & sinj);

  always @(negedge ce_n or posedge ce_n or negedge sclk) begin
    if (ce_n !== ce_d) begin
      if (ce_n) latch_m <= sr_m;
      else      sr_m    <= lvl;
      ce_d = ce_n;
    end else if (!ce_n && !sclk) begin
      sr_m <= {sr_m[6:0], si};
    end
  end

  always @(posedge sclk) if (!ce_n) so_m <= sr_m[7];

  // Pin timing monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (ce_n != prev_ce && (sclk || prev_sclk)) bad_edge++;
    if (sclk) hi_run++;
    else if (prev_sclk) begin
      if (hi_run < min_hi) min_hi = hi_run;
      hi_run = 0;
    end
    if (!ce_n && sclk && !prev_sclk) begin
      if (lo_run < min_lo) min_lo = lo_run;
      lo_run = 0;
    end else if (!ce_n && !sclk) lo_run++;
    if (ce_n) lo_run = 0;
    if (!ce_n && prev_ce) begin
      if (falls > 0 && gap_run < min_gap) min_gap = gap_run;
      falls++;
      gap_run = 0;
    end
    if (ce_n) gap_run++;
    prev_sclk = sclk;
    prev_ce = ce_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    hi_run = 0; lo_run = 0; gap_run = 0;
    min_hi = 1 << 20; min_lo = 1 << 20; min_gap = 1 << 20;
    falls = 0; bad_edge = 0;
  endtask

  task automatic launch(input logic [7:0] c, input logic [7:0] s, input logic [7:0] o);
    sinj = s; oinj = o;
    clear_stats();
    ctrl = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
    check(n < LIMIT, "R8 done timeout", n, LIMIT);
  endtask

  task automatic judge(input logic [7:0] c, input logic [7:0] s, input logic [7:0] o);
    logic [7:0] exp_s, exp_o;
    exp_s = ~c & s;
    exp_o = c & o;
    check(short_f == exp_s, "R6 short flags (R3 SO sampling)", short_f, exp_s);
    check(open_f == exp_o, "R7 open flags", open_f, exp_o);
    check(latch_m == c, "R1 driver latch after sequence (R3 SI timing)", latch_m, c);
    check(falls == 2, "R5 transfer count", falls, 2);
    check(min_gap >= SETTLE, "R5 settle gap", min_gap, SETTLE);
    check(min_hi == HALF, "R4 sclk high time", min_hi, HALF);
    check(min_lo == HALF, "R4 sclk low time", min_lo, HALF);
    check(bad_edge == 0, "R2 sclk low at CE edges", bad_edge, 0);
    check(busy == 1'b0, "R8 busy low with done", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    clear_stats();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(ce_n == 1'b1 && sclk == 1'b0 && si == 1'b1, "R10 pins after reset",
          {ce_n, sclk, si}, 3'b101);
    check(busy == 1'b0 && done == 1'b0, "R10 busy/done after reset", {busy, done}, 0);
    check(short_f == 8'h00 && open_f == 8'h00, "R10 flags after reset", {short_f, open_f}, 0);

    // Vector table
    for (int k = 0; k < NVEC; k++) begin
      launch(VEC[k][23:16], VEC[k][15:8], VEC[k][7:0]);
      check(busy == 1'b1, "R8 busy after start", busy, 1);
      wait_done();
      judge(VEC[k][23:16], VEC[k][15:8], VEC[k][7:0]);
      @(negedge clk);
      check(done == 1'b0, "R8 done one cycle", done, 0);
      repeat (3) @(negedge clk);
      check(short_f == (~VEC[k][23:16] & VEC[k][15:8]), "R8 flags held", short_f,
            ~VEC[k][23:16] & VEC[k][15:8]);
    end

    // R9: start while busy is ignored
    launch(8'h5A, 8'hFF, 8'hFF);
    repeat (40) @(negedge clk);
    ctrl = 8'hC3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    judge(8'h5A, 8'hFF, 8'hFF);
    check(latch_m == 8'h5A, "R9 byte kept on busy start", latch_m, 8'h5A);
    repeat (5) @(negedge clk);
    check(busy == 1'b0, "R9 no extra run after busy start", busy, 0);

    // R9/R8: start in the done cycle is accepted
    launch(8'h96, 8'h00, 8'hFF);
    wait_done();
    judge(8'h96, 8'h00, 8'hFF);
    launch(8'h69, 8'hFF, 8'h00);
    check(busy == 1'b1, "R9 start in done cycle accepted", busy, 1);
    wait_done();
    judge(8'h69, 8'hFF, 8'h00);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule